// File: doc/BRIEF.md
# Unlock-Sequence Flash Bank Programmer

This controller erases or programs one bank of a byte-wide parallel flash whose commands are only accepted after a two-write unlock preamble. The flash address is split into a bank index and an in-bank offset. Every command write lands at a fixed in-bank offset of the chosen bank. The host picks the bank and the operation and pulses `start`. For a program, the block fetches each source byte through a byte-read port. The port is addressed by `src_addr` and answers combinationally on `src_data`.

Every flash write is a single-cycle strobe followed by a settle gap. After each erase, and after each programmed byte, the block polls the bank base with pairs of back-to-back reads until both reads of a pair agree. The device is finished when the toggling bit stops, so the two reads match. A bounded number of failed pairs ends the operation with a timeout. The block then writes the read-mode reset command and reads the whole bank back to verify it. It ends with a one-cycle `done` pulse.

Top module: `flash_bank_prog`

## Requirements
- R1: Every command opens with the unlock pair: 0xAA written to in-bank offset 0x555, then 0x55 written to in-bank offset 0x2AA. The flash address is {bank index, in-bank offset}, so the bank base is bank × BANK_BYTES.
- R2: An erase (`op_prog`=0) writes, after the unlock pair, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and 0x30@offset 0, in that order.
- R3: A program (`op_prog`=1) handles bytes in ascending offset order. For each byte it writes the unlock pair, then 0xA0@0x555, then `src_data` at that byte's offset, with `src_addr` equal to the offset.
- R4: Each write asserts `fl_we` for exactly one cycle. It is followed by GAP_CYC cycles in which neither `fl_we` nor `fl_re` is asserted.
- R5: Completion polling reads offset 0 of the bank twice in consecutive cycles. If the two values are equal, the pending erase or byte program is complete.
- R6: After POLL_LIMIT unequal pairs, `timeout` is set and no further bytes are programmed.
- R7: When the operation ends, whether by completion or by timeout, 0xF0 is written to offset 0 of the bank.
- R8: The bank is then read at every offset. A byte that differs from 0xFF after an erase, or from the source byte after a program, sets `verify_fail`.
- R9: `done` is high for exactly one cycle after the last verify read. `busy` is high from the accepted start until that cycle.
- R10: A `start` while `busy` is ignored. `timeout` and `verify_fail` hold their value until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_prog | input | 1 | 1 = program bank from source, 0 = erase bank |
| bank | input | BW | Bank index |
| src_addr | output | OW | Offset of the source byte wanted |
| src_data | input | 8 | Source byte at `src_addr` (combinational) |
| fl_addr | output | AW | Flash byte address {bank, offset} |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data (combinational) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout | output | 1 | Sticky: polling gave up |
| verify_fail | output | 1 | Sticky: readback mismatch |

## Verification
A scoreboard compares every flash write against the expected stream, so a missing unlock, a swapped offset or a wrong erase constant shows up as a mismatch at that write. A flash model that toggles forever checks the timeout path: a design that kept going would emit the next byte's unlock writes, and one that skipped the reset command would leave the queue non-empty. An erase with a corrupted byte must raise `verify_fail`, and a second start during an erase must add no writes. Flags left over from a failed run must clear at the next accepted start.

// File: rtl/flash_bank_prog.sv
module flash_bank_prog #(
  parameter int BANK_BYTES = 8192,
  parameter int NBANKS     = 2,
  parameter int GAP_CYC    = 100,
  parameter int POLL_LIMIT = 1000000,
  localparam int OW = $clog2(BANK_BYTES),
  localparam int BW = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  localparam int AW = OW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_prog,
  input  logic [BW-1:0] bank,
  output logic [OW-1:0] src_addr,
  input  logic [7:0]    src_data,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [7:0]    fl_rdata,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          verify_fail
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [OW-1:0] OFF_A = OW'(12'h555);
  localparam logic [OW-1:0] OFF_B = OW'(12'h2AA);
  localparam logic [OW-1:0] LAST  = '1;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_GAP, S_RD1, S_RD2, S_VER} st_t;
  st_t st;

  logic          op_q, fin_q, to_q, vf_q, done_q;
  logic [BW-1:0] bank_q;
  logic [OW-1:0] idx_q;
  logic [2:0]    step_q;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] pcnt;
  logic [7:0]    rd_q;

  logic [OW-1:0] cmd_off;
  logic [7:0]    cmd_dat;
  logic          cmd_last;

  always_comb begin
    cmd_off  = '0;
    cmd_dat  = 8'h30;
    cmd_last = 1'b0;
    if (fin_q) begin
      cmd_dat  = 8'hF0;
      cmd_last = 1'b1;
    end else begin
      case (step_q)
        3'd0: begin cmd_off = OFF_A; cmd_dat = 8'hAA; end
        3'd1: begin cmd_off = OFF_B; cmd_dat = 8'h55; end
        3'd2: begin cmd_off = OFF_A; cmd_dat = op_q ? 8'hA0 : 8'h80; end
        3'd3: begin
          if (op_q) begin
            cmd_off = idx_q; cmd_dat = src_data; cmd_last = 1'b1;
          end else begin
            cmd_off = OFF_A; cmd_dat = 8'hAA;
          end
        end
        3'd4:    begin cmd_off = OFF_B; cmd_dat = 8'h55; end
        default: begin cmd_off = '0; cmd_dat = 8'h30; cmd_last = 1'b1; end
      endcase
    end
  end

  wire [7:0] ver_exp = op_q ? src_data : 8'hFF;

  assign fl_we       = (st == S_WR);
  assign fl_re       = (st == S_RD1) || (st == S_RD2) || (st == S_VER);
  assign fl_wdata    = cmd_dat;
  assign fl_addr     = {bank_q, (st == S_WR) ? cmd_off : ((st == S_VER) ? idx_q : '0)};
  assign src_addr    = idx_q;
  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign timeout     = to_q;
  assign verify_fail = vf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= 1'b0; fin_q <= 1'b0; to_q <= 1'b0; vf_q <= 1'b0; done_q <= 1'b0;
      bank_q <= '0; idx_q <= '0; step_q <= '0; gcnt <= '0; pcnt <= '0; rd_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= op_prog; bank_q <= bank;
          to_q <= 1'b0; vf_q <= 1'b0;
          idx_q <= '0; step_q <= '0; fin_q <= 1'b0;
          st <= S_WR;
        end
        S_WR: begin
          gcnt <= '0;
          st <= S_GAP;
        end
        S_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            if (fin_q) begin
              idx_q <= '0;
              st <= S_VER;
            end else if (cmd_last) begin
              pcnt <= '0;
              st <= S_RD1;
            end else begin
              step_q <= step_q + 3'd1;
              st <= S_WR;
            end
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        S_RD1: begin
          rd_q <= fl_rdata;
          st <= S_RD2;
        end
        S_RD2: begin
          if (fl_rdata == rd_q) begin
            if (op_q && idx_q != LAST) begin
              idx_q <= idx_q + OW'(1);
              step_q <= '0;
            end else begin
              fin_q <= 1'b1;
            end
            st <= S_WR;
          end else if (pcnt == PW'(POLL_LIMIT - 1)) begin
            to_q <= 1'b1;
            fin_q <= 1'b1;
            st <= S_WR;
          end else begin
            pcnt <= pcnt + PW'(1);
            st <= S_RD1;
          end
        end
        S_VER: begin
          if (fl_rdata != ver_exp) vf_q <= 1'b1;
          if (idx_q == LAST) begin
            done_q <= 1'b1;
            st <= S_IDLE;
          end else begin
            idx_q <= idx_q + OW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  assert_gap_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |=> !fl_we && !fl_re);
  assert_poll_at_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD1 || st == S_RD2) |-> (fl_addr[OW-1:0] == '0) && !fl_we);
  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PW'(POLL_LIMIT));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q) && $stable(bank_q));
  assert_to_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_q) |-> $past(start && !busy));
  assert_vf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vf_q) |-> $past(start && !busy));
endmodule

// File: tb/sim_flash_bank_prog.sv
module sim_flash_bank_prog;
  localparam int CLK_PERIOD = 10;
  localparam int BB = 4096;
  localparam int NB = 2;
  localparam int GAP = 1;
  localparam int PL = 8;
  localparam int OW = $clog2(BB);
  localparam int BW = 1;
  localparam int AW = OW + BW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_prog = 1'b0;
  logic [BW-1:0] bank = '0;
  logic [OW-1:0] src_addr;
  logic [7:0] src_data, fl_wdata, fl_rdata;
  logic [AW-1:0] fl_addr;
  logic fl_we, fl_re, busy, done, timeout, verify_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bank_prog #(.BANK_BYTES(BB), .NBANKS(NB), .GAP_CYC(GAP), .POLL_LIMIT(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .bank(bank),
    .src_addr(src_addr), .src_data(src_data), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata), .busy(busy), .done(done),
    .timeout(timeout), .verify_fail(verify_fail));

  function automatic logic [7:0] pat(input logic [OW-1:0] a);
    return (a[7:0] ^ 8'h3C ^ {4'h0, a[11:8]}) & 8'h7F;
  endfunction
  assign src_data = pat(src_addr);

  logic [7:0] fmem [0:NB*BB-1];
  int tgl_left = 0;
  logic tog = 1'b0, stuck_mode = 1'b0, corrupt_mode = 1'b0;
  logic [7:0] last_wd = 8'h00;
  logic [OW-1:0] last_off = '0;
  int bad_poll = 0;

  initial for (int i = 0; i < NB*BB; i++) fmem[i] = 8'h00;

  assign fl_rdata = (tgl_left > 0) ? {1'b0, tog, 6'b0} : fmem[fl_addr];

  always @(posedge clk) begin
    if (fl_we) begin
      if (last_wd == 8'hA0 && last_off == OW'(12'h555)) begin
        fmem[fl_addr] <= fmem[fl_addr] & fl_wdata;
        tgl_left <= stuck_mode ? (1 << 30) : 3;
      end else if (fl_wdata == 8'hF0 && fl_addr[OW-1:0] == '0) begin
        tgl_left <= 0;
      end else if (fl_wdata == 8'h30) begin
        for (int i = 0; i < BB; i++) fmem[{fl_addr[AW-1:OW], OW'(i)}] <= 8'hFF;
        if (corrupt_mode) fmem[{fl_addr[AW-1:OW], OW'(7)}] <= 8'h7F;
        tgl_left <= stuck_mode ? (1 << 30) : 5;
      end
      last_wd <= fl_wdata;
      last_off <= fl_addr[OW-1:0];
    end
    if (fl_re && tgl_left > 0) begin
      tog <= ~tog;
      tgl_left <= tgl_left - 1;
      if (fl_addr[OW-1:0] != '0) bad_poll <= bad_poll + 1;
    end
  end

  int checks = 0, errors = 0;
  logic [AW+7:0] expq [$];
  int done_cnt = 0, since_wr = 1000, gap_bad = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push_w(input logic [BW-1:0] b, input logic [OW-1:0] off, input logic [7:0] d);
    expq.push_back({b, off, d});
  endtask

  task automatic push_unlock(input logic [BW-1:0] b);
    push_w(b, OW'(12'h555), 8'hAA);
    push_w(b, OW'(12'h2AA), 8'h55);
  endtask

  task automatic push_erase(input logic [BW-1:0] b);
    push_unlock(b);
    push_w(b, OW'(12'h555), 8'h80);
    push_w(b, OW'(12'h555), 8'hAA);
    push_w(b, OW'(12'h2AA), 8'h55);
    push_w(b, '0, 8'h30);
    push_w(b, '0, 8'hF0);
  endtask

  task automatic push_prog(input logic [BW-1:0] b, input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      push_unlock(b);
      push_w(b, OW'(12'h555), 8'hA0);
      push_w(b, OW'(i), pat(OW'(i)));
    end
    push_w(b, '0, 8'hF0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if ((fl_we || fl_re) && since_wr < GAP) gap_bad++;
      if (fl_we) begin
        since_wr = 0;
        if (expq.size() == 0) begin
          chk(1'b0, "R1 R2 R3 R7 unexpected write", int'({fl_addr, fl_wdata}), 0);
        end else begin
          logic [AW+7:0] e;
          e = expq.pop_front();
          chk({fl_addr, fl_wdata} == e, "R1 R2 R3 R7 write sequence",
              int'({fl_addr, fl_wdata}), int'(e));
        end
      end else if (since_wr < 1000) begin
        since_wr++;
      end
    end
  end

  task automatic pulse_start(input bit op, input logic [BW-1:0] b);
    @(negedge clk);
    op_prog = op; bank = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  int cyc = 0;
  bit wd_hit = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !wd_hit) begin
      wd_hit = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R9 reset busy/done", {busy, done}, 0);
    chk(!timeout && !verify_fail, "R10 reset flags", {timeout, verify_fail}, 0);
    chk(!fl_we && !fl_re, "R4 reset strobes", {fl_we, fl_re}, 0);

    // erase bank0 with one corrupted byte
    corrupt_mode = 1'b1;
    push_erase(1'b0);
    pulse_start(1'b0, 1'b0);
    chk(busy, "R9 busy after start", busy, 1);
    wait_done();
    corrupt_mode = 1'b0;
    chk(verify_fail, "R8 erase verify catches bad byte", verify_fail, 1);
    chk(!timeout, "R6 no timeout on erase", timeout, 0);
    chk(expq.size() == 0, "R2 erase writes all seen", expq.size(), 0);
    chk(done_cnt == 1, "R9 one done pulse", done_cnt, 1);

    // program bank0 with a device that never settles
    stuck_mode = 1'b1;
    push_prog(1'b0, 1);
    pulse_start(1'b1, 1'b0);
    wait_done();
    stuck_mode = 1'b0;
    chk(timeout, "R6 timeout set", timeout, 1);
    chk(expq.size() == 0, "R6 R7 truncated program then reset", expq.size(), 0);
    chk(fmem[{1'b0, OW'(1)}] == 8'hFF, "R6 no further byte programmed",
        fmem[{1'b0, OW'(1)}], 8'hFF);
    chk(verify_fail, "R8 program verify mismatch", verify_fail, 1);

    // erase bank1, with an ignored start while busy
    push_erase(1'b1);
    pulse_start(1'b0, 1'b1);
    chk(!timeout && !verify_fail, "R10 flags cleared by new start",
        {timeout, verify_fail}, 0);
    repeat (6) @(negedge clk);
    pulse_start(1'b1, 1'b0);
    wait_done();
    chk(expq.size() == 0, "R10 start while busy ignored", expq.size(), 0);
    chk(done_cnt == 3, "R10 R9 single done for ignored start", done_cnt, 3);
    chk(!verify_fail && !timeout, "R8 clean erase", {timeout, verify_fail}, 0);
    chk(fmem[{1'b1, OW'(100)}] == 8'hFF, "R2 bank1 erased", fmem[{1'b1, OW'(100)}], 8'hFF);
    chk(fmem[{1'b0, OW'(7)}] == 8'h7F, "R1 bank0 untouched by bank1 erase",
        fmem[{1'b0, OW'(7)}], 8'h7F);

    // full program of bank1
    push_prog(1'b1, BB);
    pulse_start(1'b1, 1'b1);
    wait_done();
    chk(expq.size() == 0, "R3 all program writes seen", expq.size(), 0);
    chk(!verify_fail && !timeout, "R8 clean program", {timeout, verify_fail}, 0);
    chk(fmem[{1'b1, OW'(BB-1)}] == pat(OW'(BB-1)), "R3 last byte programmed",
        fmem[{1'b1, OW'(BB-1)}], pat(OW'(BB-1)));
    chk(fmem[{1'b1, OW'(0)}] == pat(OW'(0)), "R3 first byte programmed",
        fmem[{1'b1, OW'(0)}], pat(OW'(0)));
    chk(!busy, "R9 idle after done", busy, 0);
    chk(bad_poll == 0, "R5 polls read bank base", bad_poll, 0);
    chk(gap_bad == 0, "R4 settle gap after writes", gap_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule